// File: doc/BRIEF.md
# Potentiometer Register Bank with Access Control

This block holds the register map of a four-channel digital potentiometer and serves byte-wide register requests from a serial frontend. Addresses 00h to 03h select a channel. Each of these addresses reaches one of two copies, the volatile wiper code or the non-volatile start-up code. A select bit in the access control register decides which copy is used. Addresses 04h to 0Eh hold eleven general-purpose bytes. Address 10h is the access control register. All other addresses are dead: writes to them are dropped and reads of them return zero.

A write to a non-volatile location also updates the block's own copy of that location. It then hands the address and the data to a separate write sequencer as a single-cycle pulse. That sequencer owns the storage cells and the write timing, and it reports back with a busy input. While the sequencer is busy, the block refuses every request except a read of the access control register, so that software can still poll the busy bit. The block drives one 8-bit tap code per channel. Code 00h places the wiper at the low end, FFh at the high end, and the position rises monotonically with the code. Next to the tap codes it drives a per-channel shutdown flag, so entering and leaving shutdown never changes the stored codes.

Requests come in on a valid/ready stream, and responses leave on a second valid/ready stream with one entry of storage. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high when no response is waiting, or when the waiting response is taken in the same cycle. Back-pressure on `rsp_ready` therefore stalls new requests. A response that is being held is kept unchanged.

Top module: `potreg_bank`

## Requirements
- R1: After reset, every channel tap code is 80h, `chan_shdn` is all zero and `sdo_open_drain` is 0. A read of address 10h returns 40h, which means select bit 0, shutdown-control 1 and busy 0.
- R2: When the volatile-select bit (bit 7 of 10h) is 1, a write to address 00h–03h sets that channel's tap code one cycle after acceptance and raises no `nvw_valid`. A read of that address returns the tap code.
- R3: When the volatile-select bit is 0, a write to address 00h–03h stores the byte as the channel's start-up code and also sets its tap code. A read returns the start-up code and leaves the tap code unchanged.
- R4: When the volatile-select bit is 0, addresses 04h–0Eh read and write general-purpose bytes. When it is 1, writes to them are dropped and reads of them return 00h.
- R5: Writes to 0Fh and to 11h–1Fh change nothing, and reads of these addresses return 00h.
- R6: While `nv_busy` is 1, every request except a read of 10h is refused: the response has `rsp_refused`=1 and data 00h, no state changes and no `nvw_valid` is raised.
- R7: Address 10h reads as bit 7 volatile-select, bit 6 shutdown-control, bit 5 `nv_busy` at acceptance and bit 1 output-type, with all other bits 0. A write sets bits 7, 6 and 1; bit 1 drives `sdo_open_drain`.
- R8: Writing 0 to shutdown-control sets all `chan_shdn` bits to 1 and leaves the tap codes as they were. Writing 1 clears the flags, and the same codes remain.
- R9: Each accepted request yields exactly one response in the next cycle. Write responses carry data 00h. `req_ready` = !`rsp_valid` || `rsp_ready`, and a held response keeps its data and refused flag.
- R10: Each accepted, non-refused write that reaches a non-volatile location (a start-up code or a general-purpose byte) raises `nvw_valid` for one cycle in the next cycle. At the same time `nvw_addr` carries the low four address bits and `nvw_data` carries the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Register address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_data | output | 8 | Read data (00h for writes and refusals) |
| rsp_refused | output | 1 | Request refused because the sequencer is busy |
| nv_busy | input | 1 | Non-volatile write in progress |
| nvw_valid | output | 1 | Non-volatile write request pulse |
| nvw_addr | output | 4 | Non-volatile write address |
| nvw_data | output | 8 | Non-volatile write data |
| tap_code | output | 32 | Tap codes, channel n in bits 8n+7:8n |
| chan_shdn | output | 4 | Per-channel shutdown flags |
| sdo_open_drain | output | 1 | Serial output type, 1 = open drain |

## Verification
The assertions check the stream rules on every cycle: ready when no response is waiting, held responses stay stable, and refused responses carry zero data. They also check that a non-volatile write pulse only follows an accepted write taken while the sequencer was idle, and that it names an in-range address. Finally they check that the shutdown flags move together and that tap codes move only after an accepted request. The aliasing of addresses 00h–03h between the two copies can only be shown by the bench's reference model over scripted sequences. The same holds for the start-up-code mirror into the wiper, the dead addresses and the bit layout of the access control register.

// File: rtl/potreg_pkg.sv
package potreg_pkg;

  typedef enum logic [1:0] {
    TGT_CHAN = 2'd0,
    TGT_GP   = 2'd1,
    TGT_CTRL = 2'd2,
    TGT_NONE = 2'd3
  } tgt_e;

  localparam int CTRL_VOL_BIT  = 7;
  localparam int CTRL_SHDN_BIT = 6;
  localparam int CTRL_BUSY_BIT = 5;
  localparam int CTRL_OD_BIT   = 1;

endpackage

// File: rtl/potreg_decode.sv
module potreg_decode
  import potreg_pkg::*;
#(
  parameter int NCH = 4,
  parameter int NGP = 11,
  parameter int AW  = 5,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int GW = (NGP > 1) ? $clog2(NGP) : 1
) (
  input  logic [AW-1:0] addr,
  output tgt_e          tgt,
  output logic [IW-1:0] chan_idx,
  output logic [GW-1:0] gp_idx
);

  localparam logic [AW-1:0] CTRL_ADDR = AW'(2 ** (AW - 1));
  localparam logic [AW-1:0] GP_BASE   = AW'(NCH);
  localparam logic [AW-1:0] GP_END    = AW'(NCH + NGP);

  logic [AW-1:0] gp_off;

  always_comb begin
    gp_off   = addr - GP_BASE;
    chan_idx = addr[IW-1:0];
    gp_idx   = gp_off[GW-1:0];
    if (addr < GP_BASE)        tgt = TGT_CHAN;
    else if (addr < GP_END)    tgt = TGT_GP;
    else if (addr == CTRL_ADDR) tgt = TGT_CTRL;
    else                        tgt = TGT_NONE;
  end

endmodule

// File: rtl/potreg_store.sv
module potreg_store #(
  parameter int NCH       = 4,
  parameter int NGP       = 11,
  parameter int DW        = 8,
  parameter int TAP_RESET = 128,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int GW = (NGP > 1) ? $clog2(NGP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wiper_we,
  input  logic              start_we,
  input  logic              gp_we,
  input  logic [IW-1:0]     chan_idx,
  input  logic [GW-1:0]     gp_idx,
  input  logic [DW-1:0]     wdata,
  output logic [NCH*DW-1:0] wiper_flat,
  output logic [DW-1:0]     wiper_rd,
  output logic [DW-1:0]     start_rd,
  output logic [DW-1:0]     gp_rd
);

  logic [DW-1:0] wiper_q [NCH];
  logic [DW-1:0] start_q [NCH];
  logic [DW-1:0] gp_q    [NGP];

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wiper_q[c] <= DW'(TAP_RESET);
        start_q[c] <= DW'(TAP_RESET);
      end else begin
        if (wiper_we && chan_idx == IW'(c)) wiper_q[c] <= wdata;
        if (start_we && chan_idx == IW'(c)) start_q[c] <= wdata;
      end
    end
    assign wiper_flat[c*DW +: DW] = wiper_q[c];
  end

  for (genvar g = 0; g < NGP; g++) begin : g_gp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          gp_q[g] <= '0;
      else if (gp_we && gp_idx == GW'(g))  gp_q[g] <= wdata;
    end
  end

  always_comb begin
    wiper_rd = '0;
    start_rd = '0;
    gp_rd    = '0;
    for (int c = 0; c < NCH; c++) begin
      if (chan_idx == IW'(c)) begin
        wiper_rd = wiper_q[c];
        start_rd = start_q[c];
      end
    end
    for (int g = 0; g < NGP; g++) begin
      if (gp_idx == GW'(g)) gp_rd = gp_q[g];
    end
  end

endmodule

// File: rtl/potreg_ctrl.sv
module potreg_ctrl
  import potreg_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic          vol_sel,
  output logic          shdn_ctl,
  output logic          od_sel
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vol_sel  <= 1'b0;
      shdn_ctl <= 1'b1;
      od_sel   <= 1'b0;
    end else if (we) begin
      vol_sel  <= wdata[CTRL_VOL_BIT];
      shdn_ctl <= wdata[CTRL_SHDN_BIT];
      od_sel   <= wdata[CTRL_OD_BIT];
    end
  end

endmodule

// File: rtl/potreg_bank.sv
module potreg_bank
  import potreg_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int NGP       = 11,
  parameter int DW        = 8,
  parameter int AW        = 5,
  parameter int TAP_RESET = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DW-1:0]     rsp_data,
  output logic              rsp_refused,
  input  logic              nv_busy,
  output logic              nvw_valid,
  output logic [AW-2:0]     nvw_addr,
  output logic [DW-1:0]     nvw_data,
  output logic [NCH*DW-1:0] tap_code,
  output logic [NCH-1:0]    chan_shdn,
  output logic              sdo_open_drain
);

  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int GW = (NGP > 1) ? $clog2(NGP) : 1;

  tgt_e          tgt;
  logic [IW-1:0] chan_idx;
  logic [GW-1:0] gp_idx;
  logic          vol_sel, shdn_ctl, od_sel;
  logic [DW-1:0] wiper_rd, start_rd, gp_rd, ctrl_rd, rd_val;
  logic          accept, refuse, go;
  logic          wiper_we, start_we, gp_we, ctrl_we, nvw_fire;

  potreg_decode #(.NCH(NCH), .NGP(NGP), .AW(AW)) u_decode (
    .addr     (req_addr),
    .tgt      (tgt),
    .chan_idx (chan_idx),
    .gp_idx   (gp_idx)
  );

  // accept and gate
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign refuse    = nv_busy && !(tgt == TGT_CTRL && !req_write);
  assign go        = accept && !refuse && req_write;

  assign wiper_we = go && tgt == TGT_CHAN;
  assign start_we = go && tgt == TGT_CHAN && !vol_sel;
  assign gp_we    = go && tgt == TGT_GP && !vol_sel;
  assign ctrl_we  = go && tgt == TGT_CTRL;
  assign nvw_fire = start_we || gp_we;

  potreg_store #(.NCH(NCH), .NGP(NGP), .DW(DW), .TAP_RESET(TAP_RESET)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wiper_we   (wiper_we),
    .start_we   (start_we),
    .gp_we      (gp_we),
    .chan_idx   (chan_idx),
    .gp_idx     (gp_idx),
    .wdata      (req_wdata),
    .wiper_flat (tap_code),
    .wiper_rd   (wiper_rd),
    .start_rd   (start_rd),
    .gp_rd      (gp_rd)
  );

  potreg_ctrl #(.DW(DW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (ctrl_we),
    .wdata    (req_wdata),
    .vol_sel  (vol_sel),
    .shdn_ctl (shdn_ctl),
    .od_sel   (od_sel)
  );

  always_comb begin
    ctrl_rd                = '0;
    ctrl_rd[CTRL_VOL_BIT]  = vol_sel;
    ctrl_rd[CTRL_SHDN_BIT] = shdn_ctl;
    ctrl_rd[CTRL_BUSY_BIT] = nv_busy;
    ctrl_rd[CTRL_OD_BIT]   = od_sel;
    unique case (tgt)
      TGT_CHAN: rd_val = vol_sel ? wiper_rd : start_rd;
      TGT_GP:   rd_val = vol_sel ? '0 : gp_rd;
      TGT_CTRL: rd_val = ctrl_rd;
      default:  rd_val = '0;
    endcase
  end

  // response register, one entry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_data    <= '0;
      rsp_refused <= 1'b0;
    end else if (accept) begin
      rsp_valid   <= 1'b1;
      rsp_data    <= (refuse || req_write) ? '0 : rd_val;
      rsp_refused <= refuse;
    end else if (rsp_ready) begin
      rsp_valid   <= 1'b0;
    end
  end

  // non-volatile write request pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nvw_valid <= 1'b0;
      nvw_addr  <= '0;
      nvw_data  <= '0;
    end else begin
      nvw_valid <= nvw_fire;
      if (nvw_fire) begin
        nvw_addr <= req_addr[AW-2:0];
        nvw_data <= req_wdata;
      end
    end
  end

  assign chan_shdn      = {NCH{~shdn_ctl}};
  assign sdo_open_drain = od_sel;

endmodule

// File: rtl/potreg_bank_chk.sv
module potreg_bank_chk #(
  parameter int NCH = 4,
  parameter int NGP = 11,
  parameter int DW  = 8,
  parameter int AW  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DW-1:0]     rsp_data,
  input logic              rsp_refused,
  input logic              nv_busy,
  input logic              nvw_valid,
  input logic [AW-2:0]     nvw_addr,
  input logic [NCH*DW-1:0] tap_code,
  input logic [NCH-1:0]    chan_shdn
);

  AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready); // R9

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_refused)); // R9

  AST_REFUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_refused |-> rsp_data == '0); // R6

  AST_NVW_IDLE_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    nvw_valid |-> !$past(nv_busy)); // R6

  AST_NVW_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    nvw_valid |-> $past(req_valid && req_ready && req_write)); // R10

  AST_NVW_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    nvw_valid |-> int'(nvw_addr) < NCH + NGP); // R10

  AST_SHDN_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
    chan_shdn == '0 || &chan_shdn); // R8

  AST_TAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid && req_ready) |-> $stable(tap_code)); // R2

endmodule

bind potreg_bank potreg_bank_chk #(.NCH(NCH), .NGP(NGP), .DW(DW), .AW(AW)) u_chk (.*);

// File: tb/test_potreg_bank.sv
module test_potreg_bank;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_write = 0, rsp_ready = 1, nv_busy = 0;
  logic [4:0]  req_addr = 0;
  logic [7:0]  req_wdata = 0;
  logic        req_ready, rsp_valid, rsp_refused, nvw_valid, sdo_open_drain;
  logic [7:0]  rsp_data, nvw_data;
  logic [3:0]  nvw_addr, chan_shdn;
  logic [31:0] tap_code;

  int compared = 0, mismatched = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  potreg_bank i_potreg_bank (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_refused(rsp_refused), .nv_busy(nv_busy), .nvw_valid(nvw_valid),
    .nvw_addr(nvw_addr), .nvw_data(nvw_data), .tap_code(tap_code),
    .chan_shdn(chan_shdn), .sdo_open_drain(sdo_open_drain)
  );

  // behavioural reference model
  logic [7:0] m_wip [4];
  logic [7:0] m_start [4];
  logic [7:0] m_gp [11];
  logic m_vol, m_shdn, m_od, m_rv, m_rf, m_nv;
  logic [7:0] m_rd, m_nd;
  logic [3:0] m_na;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin m_wip[i] = 8'h80; m_start[i] = 8'h80; end
      for (int i = 0; i < 11; i++) m_gp[i] = 8'h00;
      m_vol = 0; m_shdn = 1; m_od = 0; m_rv = 0; m_rf = 0; m_nv = 0;
      m_rd = 0; m_nd = 0; m_na = 0;
    end else begin
      int a;
      logic acc;
      logic [7:0] d, rd;
      acc = req_valid && (!m_rv || rsp_ready);
      if (m_rv && rsp_ready) m_rv = 0;
      m_nv = 0;
      if (acc) begin
        a = int'(req_addr); d = req_wdata; rd = 8'h00;
        m_rf = nv_busy && !(a == 16 && !req_write);
        if (!m_rf) begin
          if (req_write) begin
            if (a < 4) begin
              m_wip[a] = d;
              if (!m_vol) begin m_start[a] = d; m_nv = 1; m_na = 4'(a); m_nd = d; end
            end else if (a < 15) begin
              if (!m_vol) begin m_gp[a-4] = d; m_nv = 1; m_na = 4'(a); m_nd = d; end
            end else if (a == 16) begin
              m_vol = d[7]; m_shdn = d[6]; m_od = d[1];
            end
          end else begin
            if (a < 4) rd = m_vol ? m_wip[a] : m_start[a];
            else if (a < 15) rd = m_vol ? 8'h00 : m_gp[a-4];
            else if (a == 16) rd = {m_vol, m_shdn, nv_busy, 3'b000, m_od, 1'b0};
          end
        end
        m_rv = 1; m_rd = rd;
      end
    end
  end

  task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      for (int c = 0; c < 4; c++) cmp("tap_code", 32'(tap_code[c*8 +: 8]), 32'(m_wip[c]));
      cmp("chan_shdn", 32'(chan_shdn), m_shdn ? 32'h0 : 32'hF);
      cmp("sdo_open_drain", 32'(sdo_open_drain), 32'(m_od));
      cmp("req_ready", 32'(req_ready), 32'(!m_rv || rsp_ready));
      cmp("rsp_valid", 32'(rsp_valid), 32'(m_rv));
      if (m_rv) begin
        cmp("rsp_data", 32'(rsp_data), 32'(m_rd));
        cmp("rsp_refused", 32'(rsp_refused), 32'(m_rf));
      end
      cmp("nvw_valid", 32'(nvw_valid), 32'(m_nv));
      if (m_nv) begin
        cmp("nvw_addr", 32'(nvw_addr), 32'(m_na));
        cmp("nvw_data", 32'(nvw_data), 32'(m_nd));
      end
    end
  end

  task automatic xfer(input logic wr, input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1"; repeat (2) @(negedge clk);
    xfer(0, 5'h10, 0);
    tag = "R3";
    xfer(1, 5'h01, 8'h3C);
    xfer(1, 5'h10, 8'hC0);
    xfer(1, 5'h01, 8'h55);
    xfer(1, 5'h10, 8'h40);
    xfer(0, 5'h01, 0);
    xfer(0, 5'h02, 0);
    tag = "R2";
    xfer(1, 5'h10, 8'hC0);
    xfer(1, 5'h00, 8'h00);
    xfer(1, 5'h03, 8'hFF);
    xfer(0, 5'h03, 0);
    xfer(0, 5'h01, 0);
    tag = "R4";
    xfer(1, 5'h05, 8'hA7);
    xfer(0, 5'h05, 0);
    xfer(1, 5'h10, 8'h40);
    xfer(1, 5'h04, 8'h11);
    xfer(1, 5'h0E, 8'hEE);
    xfer(0, 5'h04, 0);
    xfer(0, 5'h0E, 0);
    xfer(0, 5'h05, 0);
    tag = "R5";
    xfer(1, 5'h0F, 8'h99);
    xfer(1, 5'h11, 8'h77);
    xfer(1, 5'h1F, 8'hFF);
    xfer(0, 5'h0F, 0);
    xfer(0, 5'h11, 0);
    xfer(0, 5'h1F, 0);
    tag = "R7";
    xfer(1, 5'h10, 8'hFF);
    xfer(0, 5'h10, 0);
    xfer(1, 5'h10, 8'h40);
    xfer(0, 5'h10, 0);
    tag = "R8";
    xfer(1, 5'h10, 8'h00);
    repeat (2) @(negedge clk);
    xfer(1, 5'h10, 8'h40);
    xfer(0, 5'h00, 0);
    tag = "R6";
    @(negedge clk); nv_busy = 1;
    xfer(0, 5'h10, 0);
    xfer(1, 5'h02, 8'h12);
    xfer(1, 5'h10, 8'h80);
    xfer(0, 5'h04, 0);
    xfer(1, 5'h06, 8'h34);
    @(negedge clk); nv_busy = 0;
    xfer(0, 5'h02, 0);
    xfer(0, 5'h10, 0);
    tag = "R9";
    @(negedge clk); rsp_ready = 0;
    xfer(0, 5'h0E, 0);
    fork
      xfer(1, 5'h02, 8'h21);
      begin repeat (3) @(negedge clk); rsp_ready = 1; end
    join
    tag = "R10";
    xfer(1, 5'h0D, 8'h5A);
    xfer(1, 5'h03, 8'hC3);
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule